// File: doc/BRIEF.md
# Cascaded Command Loader with Fault Counting

This block sits behind the byte deserializer of a cascaded LED-driver serial chain. Each frame arrives as a burst of payload bytes, most significant bit first, with a 2-bit command code held steady for the whole frame and a one-cycle end-of-frame strobe after the last byte. On the end strobe the loader checks the byte count against the length the command requires. If the count matches, it routes the payload to one of four destinations: the per-output PWM staging bank, the three colour calibration registers, the global-intensity staging register or the configuration register. If the count is wrong, the frame is dropped.

The destinations follow different update rules. Calibration and configuration values take effect on the clock edge that ends the frame. PWM and global values wait in staging registers until the next frame-boundary tick, which marks subframe 0 and count 0. The configuration counter-clear bit stays set for a single cycle and then clears itself. The global value is masked so that it is right-aligned to 7 bits in single-bank mode and to 6 bits in two-bank mode.

The loader also tracks die over-temperature with hysteresis. While the die is hot, all PWM outputs are forced to zero. A diagnostic counter arrives from upstream in the serial stream. At each frame end the loader adds at most one to it and passes it on, tagged with the frame's command code, so that a host can tell open-load faults from thermal faults.

Top module: `cl_cmd_loader`

## Requirements
- R1: After reset, every output is zero: calibration, configuration, global, PWM, thermal flag, fault count and fault command.
- R2: A frame with command 01 and exactly 3 bytes writes the bytes, in arrival order, to red, green and blue calibration. The new values are visible after the end-strobe edge. No other command changes calibration.
- R3: A frame with command 11 and exactly 3 bytes loads the last byte received into the configuration register. The update happens on the end-strobe edge. Bits 7..5 read 0. Bit 0 selects two-bank mode. Bit 3 enables the PWM outputs. Bit 4 is the global-quarter flag, which is stored only. Bit 1 is the watchdog-enable flag, which is stored only.
- R4: Configuration bit 2 (counter clear) reads 1 for exactly one cycle after a load that sets it, and then reads 0.
- R5: A frame with command 10 and exactly 3 bytes stages the last byte, masked with 0x7F in single-bank mode or 0x3F in two-bank mode. `glb_out` takes the staged value only at the edge that samples `sf_tick`, and it changes at no other time.
- R6: In single-bank mode, a frame with command 00 and exactly NCH*PW/8 bytes (36 by default) stages NCH values of PW bits. Value k takes stream bits 12k..12k+11, first bit as MSB, and appears at `pwm_out[k*PW +: PW]`. Entries NCH..2*NCH-1 are staged as zero. The bank becomes active at the next `sf_tick`.
- R7: In two-bank mode, a frame with command 00 carries twice as many bytes (72 by default) and stages 2*NCH values in the same bit order. The bank becomes active at the next `sf_tick`.
- R8: A frame whose byte count does not match its command's length leaves every register unchanged.
- R9: `pwm_out` is all zero whenever configuration bit 3 is 0 or the thermal flag is set. Otherwise it equals the active bank.
- R10: `ot_active` sets one edge after `hot` is sampled high. It then stays set until `cool` is sampled high while `hot` is low.
- R11: On each end strobe, `fault_out` becomes `fault_in` plus one, saturating at 255, if any bit of `open_det` is set or `ot_active` is set. Otherwise it becomes `fault_in`. `fault_cmd` becomes the frame's command code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_cmd | input | 2 | Command code of the current frame |
| in_vld | input | 1 | Payload byte valid |
| in_byte | input | 8 | Payload byte |
| in_end | input | 1 | End-of-frame strobe |
| sf_tick | input | 1 | Frame-boundary tick (subframe 0, count 0) |
| open_det | input | NCH | Per-output open-load status |
| hot | input | 1 | Over-temperature trip indication |
| cool | input | 1 | Cooled-down indication |
| fault_in | input | FW | Fault count from upstream |
| cal_r | output | 8 | Red calibration |
| cal_g | output | 8 | Green calibration |
| cal_b | output | 8 | Blue calibration |
| cfg_out | output | 8 | Configuration register |
| glb_out | output | 8 | Active global intensity |
| pwm_out | output | 2*NCH*PW | Gated active PWM bank |
| ot_active | output | 1 | Thermal shutdown flag |
| fault_out | output | FW | Fault count passed downstream |
| fault_cmd | output | 2 | Command code attached to the fault count |

## Verification
The assertions take three things for granted about the inputs. The command code is held steady across a frame. `in_end` never shares a cycle with `in_vld`. Configuration frames are never back to back, because every configuration frame carries three bytes. The stimulus meets all three by driving one frame at a time from a task: the bytes go out on successive cycles, the end strobe comes alone in the following cycle, and the command changes only between frames. Ticks and temperature pulses are issued only between frames, so a staged value is never overwritten in the same edge that promotes it.

// File: rtl/cl_pkg.sv
package cl_pkg;
  typedef enum logic [1:0] {
    CMD_PWM = 2'b00,
    CMD_CAL = 2'b01,
    CMD_GLB = 2'b10,
    CMD_CFG = 2'b11
  } cmd_e;

  localparam int CFG_MUX   = 0;
  localparam int CFG_WDOG  = 1;
  localparam int CFG_CRST  = 2;
  localparam int CFG_PWMON = 3;
  localparam int CFG_QTR   = 4;

  localparam logic [7:0] CFG_MASK    = 8'h1F;
  localparam logic [7:0] GLB_MASK_NM = 8'h7F;
  localparam logic [7:0] GLB_MASK_MX = 8'h3F;
  localparam int         SHORT_LEN   = 3;
endpackage

// File: rtl/cl_frame_rx.sv
module cl_frame_rx #(
  parameter int NCH = 24,
  parameter int PW  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            in_cmd,
  input  logic                  in_vld,
  input  logic [7:0]            in_byte,
  input  logic                  in_end,
  input  logic                  mux,
  output logic                  ld_pwm,
  output logic                  ld_cal,
  output logic                  ld_glb,
  output logic                  ld_cfg,
  output logic [23:0]           last3,
  output logic [2*NCH*PW-1:0]   pwm_bits
);
  import cl_pkg::*;

  localparam int TOT_MX   = 2 * NCH * PW;
  localparam int BYTES_NM = NCH * PW / 8;
  localparam int BYTES_MX = 2 * BYTES_NM;
  localparam int CW       = $clog2(BYTES_MX + 2);
  localparam logic [CW-1:0] CNT_SAT   = CW'(BYTES_MX + 1);
  localparam logic [CW-1:0] CNT_NM    = CW'(BYTES_NM);
  localparam logic [CW-1:0] CNT_MX    = CW'(BYTES_MX);
  localparam logic [CW-1:0] CNT_SHORT = CW'(SHORT_LEN);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [23:0]       l3_q, l3_d;
  logic [TOT_MX-1:0] sh_q, sh_d;
  logic              sh_en;
  logic              short_ok, pwm_ok;

  // next-state
  always_comb begin
    cnt_d = cnt_q;
    if (in_end) begin
      cnt_d = '0;
    end else if (in_vld && (cnt_q != CNT_SAT)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign sh_en = in_vld && (in_cmd == CMD_PWM);
  assign l3_d  = {l3_q[15:0], in_byte};
  assign sh_d  = {sh_q[TOT_MX-9:0], in_byte};

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l3_q <= '0;
    end else if (in_vld) begin
      l3_q <= l3_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  // length qualification at end of frame
  assign short_ok = (cnt_q == CNT_SHORT);
  assign pwm_ok   = mux ? (cnt_q == CNT_MX) : (cnt_q == CNT_NM);

  assign ld_pwm = in_end && (in_cmd == CMD_PWM) && pwm_ok;
  assign ld_cal = in_end && (in_cmd == CMD_CAL) && short_ok;
  assign ld_glb = in_end && (in_cmd == CMD_GLB) && short_ok;
  assign ld_cfg = in_end && (in_cmd == CMD_CFG) && short_ok;

  assign last3    = l3_q;
  assign pwm_bits = sh_q;
endmodule

// File: rtl/cl_pwm_bank.sv
module cl_pwm_bank #(
  parameter int NCH = 24,
  parameter int PW  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_pwm,
  input  logic                mux,
  input  logic                sf_tick,
  input  logic [2*NCH*PW-1:0] pwm_bits,
  output logic [2*NCH*PW-1:0] act
);
  localparam int NVAL   = 2 * NCH;
  localparam int TOT_MX = NVAL * PW;
  localparam int TOT_NM = NCH * PW;

  logic [TOT_MX-1:0] unpk;
  logic [TOT_MX-1:0] pend_q;
  logic [TOT_MX-1:0] act_q;
  logic              pv_q, pv_d;
  logic              promote;

  // unpack: value k starts at stream bit k*PW, first bit is the MSB
  for (genvar k = 0; k < NVAL; k++) begin : g_unpk
    if (k < NCH) begin : g_lo
      assign unpk[k*PW +: PW] = mux ? pwm_bits[TOT_MX-1-k*PW -: PW]
                                    : pwm_bits[TOT_NM-1-k*PW -: PW];
    end else begin : g_hi
      assign unpk[k*PW +: PW] = mux ? pwm_bits[TOT_MX-1-k*PW -: PW]
                                    : {PW{1'b0}};
    end
  end

  assign promote = sf_tick && pv_q;
  assign pv_d    = ld_pwm || (pv_q && !sf_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
    end else begin
      pv_q <= pv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (ld_pwm) begin
      pend_q <= unpk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (promote) begin
      act_q <= pend_q;
    end
  end

  assign act = act_q;
endmodule

// File: rtl/cl_fault.sv
module cl_fault #(
  parameter int NCH = 24,
  parameter int FW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hot,
  input  logic           cool,
  input  logic           in_end,
  input  logic [1:0]     in_cmd,
  input  logic [NCH-1:0] open_det,
  input  logic [FW-1:0]  fault_in,
  output logic           ot_active,
  output logic [FW-1:0]  fault_out,
  output logic [1:0]     fault_cmd
);
  logic          ot_q, ot_d;
  logic          inc;
  logic [FW:0]   sum;
  logic [FW-1:0] sat_d;
  logic [FW-1:0] cnt_q;
  logic [1:0]    cmd_q;

  assign ot_d  = hot || (ot_q && !cool);
  assign inc   = (|open_det) || ot_q;
  assign sum   = {1'b0, fault_in} + {{FW{1'b0}}, inc};
  assign sat_d = sum[FW] ? {FW{1'b1}} : sum[FW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ot_q <= 1'b0;
    end else begin
      ot_q <= ot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmd_q <= '0;
    end else if (in_end) begin
      cnt_q <= sat_d;
      cmd_q <= in_cmd;
    end
  end

  assign ot_active = ot_q;
  assign fault_out = cnt_q;
  assign fault_cmd = cmd_q;
endmodule

// File: rtl/cl_cmd_loader.sv
module cl_cmd_loader #(
  parameter int NCH = 24,
  parameter int PW  = 12,
  parameter int FW  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          in_cmd,
  input  logic                in_vld,
  input  logic [7:0]          in_byte,
  input  logic                in_end,
  input  logic                sf_tick,
  input  logic [NCH-1:0]      open_det,
  input  logic                hot,
  input  logic                cool,
  input  logic [FW-1:0]       fault_in,
  output logic [7:0]          cal_r,
  output logic [7:0]          cal_g,
  output logic [7:0]          cal_b,
  output logic [7:0]          cfg_out,
  output logic [7:0]          glb_out,
  output logic [2*NCH*PW-1:0] pwm_out,
  output logic                ot_active,
  output logic [FW-1:0]       fault_out,
  output logic [1:0]          fault_cmd
);
  import cl_pkg::*;

  localparam int TOT = 2 * NCH * PW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_s_n = rs_q[1];

  logic        ld_pwm, ld_cal, ld_glb, ld_cfg;
  logic [23:0] last3;
  logic [TOT-1:0] pwm_bits, act;
  logic        ot_q;

  logic [7:0]  cfg_q, cfg_d;
  logic [23:0] cal_q;
  logic [7:0]  gp_q, gp_d, glb_q;
  logic        gpv_q, gpv_d;
  logic        mux;

  assign mux = cfg_q[CFG_MUX];

  cl_frame_rx #(.NCH(NCH), .PW(PW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .in_cmd   (in_cmd),
    .in_vld   (in_vld),
    .in_byte  (in_byte),
    .in_end   (in_end),
    .mux      (mux),
    .ld_pwm   (ld_pwm),
    .ld_cal   (ld_cal),
    .ld_glb   (ld_glb),
    .ld_cfg   (ld_cfg),
    .last3    (last3),
    .pwm_bits (pwm_bits)
  );

  cl_pwm_bank #(.NCH(NCH), .PW(PW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .ld_pwm   (ld_pwm),
    .mux      (mux),
    .sf_tick  (sf_tick),
    .pwm_bits (pwm_bits),
    .act      (act)
  );

  cl_fault #(.NCH(NCH), .FW(FW)) u_fault (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .hot       (hot),
    .cool      (cool),
    .in_end    (in_end),
    .in_cmd    (in_cmd),
    .open_det  (open_det),
    .fault_in  (fault_in),
    .ot_active (ot_q),
    .fault_out (fault_out),
    .fault_cmd (fault_cmd)
  );

  // configuration: last copy wins, counter-clear bit drops after one cycle
  always_comb begin
    cfg_d = cfg_q;
    cfg_d[CFG_CRST] = 1'b0;
    if (ld_cfg) begin
      cfg_d = last3[7:0] & CFG_MASK;
    end
  end

  // global: staged, masked by the bank mode at load time
  assign gp_d  = last3[7:0] & (mux ? GLB_MASK_MX : GLB_MASK_NM);
  assign gpv_d = ld_glb || (gpv_q && !sf_tick);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cfg_q <= '0;
      gpv_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      gpv_q <= gpv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cal_q <= '0;
    end else if (ld_cal) begin
      cal_q <= last3;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      gp_q <= '0;
    end else if (ld_glb) begin
      gp_q <= gp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      glb_q <= '0;
    end else if (sf_tick && gpv_q) begin
      glb_q <= gp_q;
    end
  end

  assign cal_r     = cal_q[23:16];
  assign cal_g     = cal_q[15:8];
  assign cal_b     = cal_q[7:0];
  assign cfg_out   = cfg_q;
  assign glb_out   = glb_q;
  assign ot_active = ot_q;
  assign pwm_out   = (cfg_q[CFG_PWMON] && !ot_q) ? act : '0;
endmodule

// File: rtl/cl_cmd_loader_chk.sv
module cl_cmd_loader_chk #(
  parameter int NCH = 24,
  parameter int PW  = 12,
  parameter int FW  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          in_cmd,
  input logic                in_end,
  input logic                sf_tick,
  input logic                hot,
  input logic                cool,
  input logic [FW-1:0]       fault_in,
  input logic [7:0]          cal_r,
  input logic [7:0]          cal_g,
  input logic [7:0]          cal_b,
  input logic [7:0]          cfg_out,
  input logic [7:0]          glb_out,
  input logic [2*NCH*PW-1:0] pwm_out,
  input logic                ot_active,
  input logic [FW-1:0]       fault_out,
  input logic [1:0]          fault_cmd
);
  assert_cal_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_end && in_cmd == 2'b01) |=> $stable({cal_r, cal_g, cal_b}));

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_end && in_cmd == 2'b11) |=> $stable({cfg_out[7:3], cfg_out[1:0]}));

  assert_cfg_top_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_out[7:5] == 3'b000);

  assert_crst_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_out[2] && !(in_end && in_cmd == 2'b11) |=> !cfg_out[2]);

  assert_glb_wait_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_tick |=> $stable(glb_out));

  assert_glb_msb_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    glb_out[7] == 1'b0);

  assert_pwm_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_out[3] || ot_active) |-> (pwm_out == '0));

  assert_ot_trip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hot |=> ot_active);

  assert_ot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ot_active && !cool |=> ot_active);

  assert_fault_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_end |=> (fault_out >= $past(fault_in)) && (fault_cmd == $past(in_cmd)));
endmodule

bind cl_cmd_loader cl_cmd_loader_chk #(.NCH(NCH), .PW(PW), .FW(FW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .in_cmd    (in_cmd),
  .in_end    (in_end),
  .sf_tick   (sf_tick),
  .hot       (hot),
  .cool      (cool),
  .fault_in  (fault_in),
  .cal_r     (cal_r),
  .cal_g     (cal_g),
  .cal_b     (cal_b),
  .cfg_out   (cfg_out),
  .glb_out   (glb_out),
  .pwm_out   (pwm_out),
  .ot_active (ot_active),
  .fault_out (fault_out),
  .fault_cmd (fault_cmd)
);

// File: tb/tb_cl_cmd_loader.sv
`timescale 1ns/1ps
module tb_cl_cmd_loader;
  localparam int NCH   = 24;
  localparam int PW    = 12;
  localparam int FW    = 8;
  localparam int TOT   = 2 * NCH * PW;
  localparam int NB_NM = NCH * PW / 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic [1:0]     in_cmd;
  logic           in_vld, in_end, sf_tick, hot, cool;
  logic [7:0]     in_byte;
  logic [NCH-1:0] open_det;
  logic [FW-1:0]  fault_in;
  logic [7:0]     cal_r, cal_g, cal_b, cfg_out, glb_out;
  logic [TOT-1:0] pwm_out;
  logic           ot_active;
  logic [FW-1:0]  fault_out;
  logic [1:0]     fault_cmd;

  cl_cmd_loader #(.NCH(NCH), .PW(PW), .FW(FW)) dut (
    .clk(clk), .rst_n(rst_n), .in_cmd(in_cmd), .in_vld(in_vld),
    .in_byte(in_byte), .in_end(in_end), .sf_tick(sf_tick),
    .open_det(open_det), .hot(hot), .cool(cool), .fault_in(fault_in),
    .cal_r(cal_r), .cal_g(cal_g), .cal_b(cal_b), .cfg_out(cfg_out),
    .glb_out(glb_out), .pwm_out(pwm_out), .ot_active(ot_active),
    .fault_out(fault_out), .fault_cmd(fault_cmd)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  logic [7:0]     fb [0:127];
  logic [7:0]     m_cal [0:2];
  logic [7:0]     m_cfg, m_gp, m_glb, m_fo;
  logic [1:0]     m_fc;
  logic           m_gpv, m_ppv, m_ot;
  logic [TOT-1:0] m_pend, m_act;

  task automatic chk8(string req, string what, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic chkv(string req, logic [TOT-1:0] got, logic [TOT-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s pwm_out got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [TOT-1:0] unpack(bit mx);
    logic [TOT-1:0] v = '0;
    for (int k = 0; k < 2 * NCH; k++) begin
      logic [PW-1:0] val = '0;
      if (mx || k < NCH) begin
        for (int b = 0; b < PW; b++) begin
          int s = k * PW + b;
          val[PW-1-b] = fb[s / 8][7 - (s % 8)];
        end
      end
      v[k*PW +: PW] = val;
    end
    return v;
  endfunction

  function automatic logic [TOT-1:0] exp_pwm();
    return (m_cfg[3] && !m_ot) ? m_act : '0;
  endfunction

  task automatic check_all(string req);
    chk8(req, "cal_r", cal_r, m_cal[0]);
    chk8(req, "cal_g", cal_g, m_cal[1]);
    chk8(req, "cal_b", cal_b, m_cal[2]);
    chk8(req, "cfg", cfg_out, m_cfg);
    chk8(req, "glb", glb_out, m_glb);
    chk8(req, "ot", {7'd0, ot_active}, {7'd0, m_ot});
    chk8(req, "fault", fault_out, m_fo);
    chk8(req, "fcmd", {6'd0, fault_cmd}, {6'd0, m_fc});
    chkv(req, pwm_out, exp_pwm());
  endtask

  task automatic send(logic [1:0] c, int n, logic [NCH-1:0] op, logic [FW-1:0] fi, string req);
    int need;
    logic [8:0] s;
    in_cmd = c;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b1;
      in_byte = fb[i];
    end
    @(negedge clk);
    in_vld = 1'b0;
    in_end = 1'b1;
    open_det = op;
    fault_in = fi;
    // model
    need = (c == 2'b00) ? (m_cfg[0] ? 2 * NB_NM : NB_NM) : 3;
    s = {1'b0, fi} + (((|op) || m_ot) ? 9'd1 : 9'd0);
    m_fo = s[8] ? 8'hFF : s[7:0];
    m_fc = c;
    if (n == need) begin
      case (c)
        2'b01: begin m_cal[0] = fb[0]; m_cal[1] = fb[1]; m_cal[2] = fb[2]; end
        2'b11: m_cfg = fb[n-1] & 8'h1F;
        2'b10: begin m_gp = fb[n-1] & (m_cfg[0] ? 8'h3F : 8'h7F); m_gpv = 1'b1; end
        default: begin m_pend = unpack(m_cfg[0]); m_ppv = 1'b1; end
      endcase
    end
    @(negedge clk);
    in_end = 1'b0;
    open_det = '0;
    check_all(req);
    m_cfg[2] = 1'b0;
  endtask

  task automatic tick(string req);
    @(negedge clk);
    sf_tick = 1'b1;
    if (m_gpv) m_glb = m_gp;
    if (m_ppv) m_act = m_pend;
    m_gpv = 1'b0;
    m_ppv = 1'b0;
    @(negedge clk);
    sf_tick = 1'b0;
    check_all(req);
  endtask

  task automatic temp(logic h, logic c, string req);
    @(negedge clk);
    hot = h;
    cool = c;
    m_ot = h || (m_ot && !c);
    @(negedge clk);
    hot = 1'b0;
    cool = 1'b0;
    check_all(req);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_cmd = '0; in_vld = 1'b0; in_end = 1'b0; in_byte = '0;
    sf_tick = 1'b0; hot = 1'b0; cool = 1'b0; open_det = '0; fault_in = '0;
    m_cal[0] = '0; m_cal[1] = '0; m_cal[2] = '0; m_cfg = '0; m_gp = '0;
    m_glb = '0; m_fo = '0; m_fc = '0; m_gpv = 1'b0; m_ppv = 1'b0; m_ot = 1'b0;
    m_pend = '0; m_act = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R2 calibration
    fb[0] = 8'h11; fb[1] = 8'h22; fb[2] = 8'h33;
    send(2'b01, 3, '0, 8'd0, "R2");

    // R3 last copy wins, R4 counter clear pulse
    fb[0] = 8'h1A; fb[1] = 8'h05; fb[2] = 8'hEC;
    send(2'b11, 3, '0, 8'd0, "R3");
    @(negedge clk);
    chk8("R4", "cfg_after_pulse", cfg_out, 8'h08);

    // R5 global, single-bank mask
    fb[0] = 8'h55; fb[1] = 8'h10; fb[2] = 8'hFF;
    send(2'b10, 3, '0, 8'd0, "R5");
    chk8("R5", "glb_before_tick", glb_out, 8'h00);
    tick("R5");

    // R6 single-bank PWM
    for (int i = 0; i < NB_NM; i++) fb[i] = 8'($urandom);
    send(2'b00, NB_NM, '0, 8'd0, "R6");
    chkv("R6", pwm_out, '0);
    tick("R6");

    // R8 wrong lengths
    fb[0] = 8'hAA; fb[1] = 8'hBB;
    send(2'b01, 2, '0, 8'd0, "R8");
    for (int i = 0; i < NB_NM - 1; i++) fb[i] = 8'($urandom);
    send(2'b00, NB_NM - 1, '0, 8'd0, "R8");
    tick("R8");

    // R7 two-bank mode
    fb[0] = 8'h00; fb[1] = 8'h00; fb[2] = 8'h09;
    send(2'b11, 3, '0, 8'd0, "R3");
    fb[0] = 8'hFF; fb[1] = 8'hFF; fb[2] = 8'hFF;
    send(2'b10, 3, '0, 8'd0, "R5");
    for (int i = 0; i < 2 * NB_NM; i++) fb[i] = 8'($urandom);
    send(2'b00, 2 * NB_NM, '0, 8'd0, "R7");
    tick("R7");
    chk8("R5", "glb_mux_mask", glb_out, 8'h3F);

    // R9 output enable off then on
    fb[2] = 8'h01;
    send(2'b11, 3, '0, 8'd0, "R9");
    fb[2] = 8'h09;
    send(2'b11, 3, '0, 8'd0, "R9");

    // R10 hysteresis
    temp(1'b1, 1'b0, "R10");
    temp(1'b0, 1'b0, "R10");
    // R11 with thermal flag set
    fb[0] = 8'h01; fb[1] = 8'h02; fb[2] = 8'h03;
    send(2'b01, 3, '0, 8'd7, "R11");
    temp(1'b0, 1'b1, "R10");

    // R11 open loads and saturation
    send(2'b01, 3, 24'h000100, 8'd5, "R11");
    send(2'b01, 3, 24'hFFFFFF, 8'hFF, "R11");
    send(2'b01, 3, 24'h000000, 8'h40, "R11");

    // constrained random mix
    for (int it = 0; it < 80; it++) begin
      logic [1:0] c = 2'($urandom);
      int need = (c == 2'b00) ? (m_cfg[0] ? 2 * NB_NM : NB_NM) : 3;
      int n = need;
      if ($urandom % 4 == 0) n = ($urandom % 2 == 0) ? need + 1 : need - 1;
      for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
      send(c, n, ($urandom % 3 == 0) ? NCH'($urandom) : '0, FW'($urandom), "R11");
      if ($urandom % 3 == 0) tick("R6");
      if ($urandom % 8 == 0) temp(1'b1, 1'b0, "R10");
      else if ($urandom % 5 == 0) temp(1'b0, 1'b1, "R10");
    end

    summary();
  end
endmodule